// File: doc/BRIEF.md
# Cycle Master Absence Detector

This block sits beside the link layer of an IEEE 1394 node. It watches the per-cycle status strobes and decides whether any node on the bus is acting as cycle master. Each isochronous cycle ends in one of two ways. A cycle-start packet arrives, which the link reports as a received strobe, or the cycle passes without one, which it reports as a lost strobe. The block counts lost cycles that follow one another without a received cycle in between. When that run reaches a fixed limit of 255, it reports that the bus has no cycle master.

Two static control bits from the host register file change this behaviour. The force bit asserts the absence condition no matter what the counter holds. The detector-off bit clears the counter and keeps it at zero, so absence is never concluded from lost cycles. When both bits are set, the force bit takes precedence. Both are expected to be 0 after a chip reset, which leaves the detector running and the condition not forced. The output flag is registered.

Top module: `cycle_master_watch`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it goes high with no strobes, `no_cm` is 0.
- R2: With `force_absent` = 0 and `detect_off` = 0, `no_cm` goes to 1 on the clock edge that registers the 255th consecutive lost strobe. It stays 0 after the 254th.
- R3: A clock with neither strobe neither advances the run of lost cycles nor breaks it.
- R4: A received strobe ends the run. When not forced, `no_cm` is 0 after that clock edge, and a full 255 new lost strobes are needed to raise it again.
- R5: When `lost_stb` and `rcvd_stb` are both high in the same clock, the clock counts as a received cycle.
- R6: The lost-cycle count saturates at 255. Any number of further lost strobes keeps `no_cm` at 1, and the count never wraps.
- R7: When `force_absent` = 1 at a clock edge, `no_cm` is 1 after that edge, whatever the strobes are.
- R8: When `force_absent` = 1, `detect_off` has no effect on `no_cm`.
- R9: When `detect_off` = 1 at a clock edge and `force_absent` = 0, `no_cm` is 0 after that edge and the run is cleared. After `detect_off` returns to 0, 255 new lost strobes are needed.
- R10: When `force_absent` falls, `no_cm` follows the detector on the next edge. It is 1 only if the run has reached 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lost_stb | input | 1 | One-clock strobe: a cycle ended without a cycle-start |
| rcvd_stb | input | 1 | One-clock strobe: a cycle-start was received |
| force_absent | input | 1 | Force the no-cycle-master condition |
| detect_off | input | 1 | Turn the lost-cycle detector off |
| no_cm | output | 1 | Registered no-cycle-master flag |

## Verification
The hardest states to reach from the ports are the exact boundary between 254 and 255 lost cycles and the saturated count well beyond it. The same holds for these states combined with a strobe collision, the detector-off bit, or a release of the force bit. Directed sequences drive long lost-only runs, some with idle gaps, to each of these points and then apply the disturbing input in the critical clock. A biased random phase follows. It makes lost strobes dominant and received strobes rare, so the threshold is crossed many times amid random toggling of both control bits.

// File: rtl/cmd_pkg.sv
// Package: shared types for the cycle master absence detector.
// Assumes nothing beyond the standard SystemVerilog type system.
package cmd_pkg;

    // Classified outcome of one clock's strobe inputs.
    typedef enum logic [1:0] {
        EVT_NONE = 2'd0,
        EVT_LOST = 2'd1,
        EVT_RCVD = 2'd2
    } evt_kind_e;

    // Default number of consecutive lost cycles that declares absence.
    localparam int unsigned DEF_LOSS_LIMIT = 255;

endpackage

// File: rtl/cmd_evt_qual.sv
// Module: cmd_evt_qual
// Turns the two raw cycle strobes into a single event class.
// A received strobe wins over a lost strobe in the same clock.
// Assumes the strobes are already synchronous to clk.
module cmd_evt_qual
    import cmd_pkg::*;
(
    input  logic      lost_stb,
    input  logic      rcvd_stb,
    output evt_kind_e evt
);

    // Priority select: received, then lost, then nothing.
    always_comb begin
        if (rcvd_stb)      evt = EVT_RCVD;
        else if (lost_stb) evt = EVT_LOST;
        else               evt = EVT_NONE;
    end

endmodule

// File: rtl/cmd_loss_cnt.sv
// Module: cmd_loss_cnt
// Counts consecutive lost cycles and saturates at LOSS_LIMIT.
// It clears on a received cycle and is held at zero while hold_zero is set.
// It also exports the next count's limit status so that the flag can be
// registered on the same edge. Assumes a synchronous active-low reset.
module cmd_loss_cnt
    import cmd_pkg::*;
#(
    parameter int unsigned LOSS_LIMIT = DEF_LOSS_LIMIT,
    localparam int unsigned CNT_W     = $clog2(LOSS_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_zero,
    input  evt_kind_e        evt,
    output logic [CNT_W-1:0] cnt_q,
    output logic             limit_next
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LOSS_LIMIT);

    logic [CNT_W-1:0] cnt_d;

    // Next-count selection: clear, saturating increment, or hold.
    always_comb begin
        cnt_d = cnt_q;
        if (hold_zero) begin
            cnt_d = '0;
        end else begin
            unique case (evt)
                EVT_RCVD: cnt_d = '0;
                EVT_LOST: cnt_d = (cnt_q == LIMIT_V) ? cnt_q : cnt_q + 1'b1;
                default:  cnt_d = cnt_q;
            endcase
        end
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Limit status of the value about to be stored.
    always_comb limit_next = (cnt_d == LIMIT_V);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT_V);

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LIMIT_V && evt == EVT_LOST && !hold_zero) |=> cnt_q == LIMIT_V);

    // R9
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_zero |=> cnt_q == '0);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EVT_NONE && !hold_zero) |=> $stable(cnt_q));

endmodule

// File: rtl/cmd_flag_reg.sv
// Module: cmd_flag_reg
// Registers the no-cycle-master flag. Force wins over everything else,
// and the detector-off bit suppresses the detected part.
// Assumes limit_next describes the counter value stored on the same edge.
module cmd_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic force_absent,
    input  logic detect_off,
    input  logic limit_next,
    output logic flag_q
);

    logic flag_d;

    // Combine the forced and detected sources.
    always_comb flag_d = force_absent | (~detect_off & limit_next);

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    // R7
    force_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_absent |=> flag_q);

    // R8
    force_over_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_absent && detect_off) |=> flag_q);

    // R9
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_off && !force_absent) |=> !flag_q);

endmodule

// File: rtl/cycle_master_watch.sv
// Module: cycle_master_watch (top)
// Decides whether a cycle master is absent from the bus, using the link
// layer's per-cycle lost and received strobes and two host control bits.
// Assumes all inputs are synchronous to clk. The reset is synchronous and
// active low.
module cycle_master_watch
    import cmd_pkg::*;
#(
    parameter int unsigned LOSS_LIMIT = DEF_LOSS_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lost_stb,
    input  logic rcvd_stb,
    input  logic force_absent,
    input  logic detect_off,
    output logic no_cm
);

    localparam int unsigned CNT_W = $clog2(LOSS_LIMIT + 1);

    evt_kind_e        evt;
    logic [CNT_W-1:0] run_cnt;
    logic             at_limit_next;

    cmd_evt_qual u_qual (
        .lost_stb (lost_stb),
        .rcvd_stb (rcvd_stb),
        .evt      (evt)
    );

    cmd_loss_cnt #(.LOSS_LIMIT(LOSS_LIMIT)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_zero  (detect_off),
        .evt        (evt),
        .cnt_q      (run_cnt),
        .limit_next (at_limit_next)
    );

    cmd_flag_reg u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_absent (force_absent),
        .detect_off   (detect_off),
        .limit_next   (at_limit_next),
        .flag_q       (no_cm)
    );

    // R5
    collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_stb && rcvd_stb && !detect_off) |=> run_cnt == '0);

    // R4
    rcvd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rcvd_stb && !force_absent) |=> !no_cm);

    // R2
    rise_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(no_cm) && !$past(force_absent)) |-> run_cnt == CNT_W'(LOSS_LIMIT));

endmodule

// File: tb/cycle_master_watch_tb_top.sv
module cycle_master_watch_tb_top;

    localparam int LIMIT = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lost_stb = 1'b0;
    logic rcvd_stb = 1'b0;
    logic force_absent = 1'b0;
    logic detect_off = 1'b0;
    logic no_cm;

    int checks = 0;
    int errors = 0;
    int mcnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cycle_master_watch dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lost_stb     (lost_stb),
        .rcvd_stb     (rcvd_stb),
        .force_absent (force_absent),
        .detect_off   (detect_off),
        .no_cm        (no_cm)
    );

    // Reference model: next run length from the requirements.
    function automatic int next_run(int c, bit l, bit r, bit o);
        if (o)      return 0;
        if (r)      return 0;
        if (l)      return (c >= LIMIT) ? LIMIT : c + 1;
        return c;
    endfunction

    // Reference model: expected flag after an edge.
    function automatic bit exp_flag(int c, bit f);
        return f || (c == LIMIT);
    endfunction

    task automatic check(input bit exp, input string tag);
        checks++;
        if (no_cm !== exp) begin
            errors++;
            $display("FAIL %s: no_cm=%0b expected %0b (t=%0t)", tag, no_cm, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update the model, sample after the rising edge.
    task automatic step(input bit l, input bit r, input bit f, input bit o, input string tag);
        bit fe;
        @(negedge clk);
        lost_stb = l; rcvd_stb = r; force_absent = f; detect_off = o;
        @(posedge clk);
        if (!rst_n) begin mcnt = 0; fe = 1'b0; end
        else begin mcnt = next_run(mcnt, l, r, o); fe = exp_flag(mcnt, f); end
        #2;
        check(fe, tag);
    endtask

    task automatic lost_run(input int n, input bit f, input bit o, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, f, o, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        bit l, r, f, o;
        void'($urandom(32'd20240611));
        // R1: reset state
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, "R1");

        // R2: 254 lost keeps 0, the 255th raises the flag
        lost_run(254, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R2");

        // R6: saturation, no wrap
        lost_run(300, 1'b0, 1'b0, "R6");

        // R4: received clears
        step(1'b0, 1'b1, 1'b0, 1'b0, "R4");
        // R3: idle gaps inside the run
        for (int i = 0; i < 254; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
            if (i % 3 == 0) step(1'b0, 1'b0, 1'b0, 1'b0, "R3");
        end
        step(1'b1, 1'b0, 1'b0, 1'b0, "R3");

        // R5: collision counts as received, also at 254
        step(1'b1, 1'b1, 1'b0, 1'b0, "R5");
        lost_run(254, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R5");
        lost_run(255, 1'b0, 1'b0, "R5");

        // R9: detector off clears and holds
        step(1'b1, 1'b0, 1'b0, 1'b1, "R9");
        lost_run(300, 1'b0, 1'b1, "R9");
        lost_run(254, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R9");

        // R7: force with a received strobe
        step(1'b0, 1'b1, 1'b1, 1'b0, "R7");
        // R8: force beats detector off
        lost_run(20, 1'b1, 1'b1, "R8");
        // R10: release while off and empty run -> 0
        step(1'b0, 1'b0, 1'b0, 1'b1, "R10");
        // R10: reach the limit under force, release -> stays 1
        lost_run(260, 1'b1, 1'b0, "R10");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
        // R10: release with a short run -> 0
        step(1'b0, 1'b1, 1'b1, 1'b0, "R10");
        lost_run(10, 1'b1, 1'b0, "R10");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R10");

        // Biased random phase
        f = 1'b0; o = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            l = ($urandom % 16) != 0;
            r = ($urandom % 700) == 0;
            if (($urandom % 1500) == 0) f = ~f;
            if (($urandom % 1200) == 0) o = ~o;
            step(l, r, f, o, "R3");
        end

        finish_run();
    end

endmodule